// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A countdown watchdog that a processor keeps alive by writing two fixed key words, in order, to a service register. Software sets a timeout in half-second units and turns the counter on through a control register. A slow tick input, one pulse per half second, drives the countdown. If software fails to service the watchdog in time, the block issues a one-cycle system reset request. It also records in a status register that the watchdog caused the last reset. Software can choose to hold a separate timeout pin high after expiry. Three suspend inputs, for low-power, debug halt and wait, can pause the countdown when their matching control bits are set.

The register interface holds 16-bit words and uses halfword offsets. Reads are combinational from the address. Two resets feed the block. The power-on reset clears everything. The system reset, which the watchdog's own request is expected to cause, clears everything except the reset status. Each reset is asserted asynchronously and released in step with the clock.

Top module: `keysvc_wdog`

## Requirements
- R1: The control register sits at offset 0x0, the service register at 0x2 and the status register at 0x4. Control reads back the timeout field in bits [15:8] and the mode bits 7, 3, 2, 1 and 0. Control bits 6..4 read as 0. Service and all other offsets read 0.
- R2: A write of 0x5555 to the service register, followed by a write of 0xAAAA, reloads the counter to N+1 ticks. A repeated 0x5555 before the 0xAAAA still counts as a valid start.
- R3: Any other service write clears the pending first key. A 0xAAAA that does not directly follow 0x5555 leaves the count unchanged.
- R4: With timeout field N, the reset request fires on the (N+1)th counted tick after a reload. N=0 fires on the first tick.
- R5: Control bit 2 is the enable. A 1 written to it sets it. Writing 0 does not clear it; only a system or power-on reset does. While it is clear, ticks have no effect and no reset request occurs.
- R6: The reset request is high for exactly one clock, in the clock after the edge that took the expiring tick. The count then restarts at N+1.
- R7: The timeout pin goes high one clock after a reset request only if control bit 3 is set. It stays high until a system reset.
- R8: The low-power, debug and wait suspend inputs freeze the countdown only when control bits 0, 1 and 7, respectively, are set.
- R9: The status register reads 0x0001 after power-on reset and 0x0002 after a watchdog expiry. The value survives a system reset, and writes to it are ignored.
- R10: Rewriting the timeout field while the counter is enabled does not change the running count. The new value applies at the next reload.
- R11: The control write that sets the enable loads the counter with N+1 taken from that same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Halfword byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| tick_half | input | 1 | Half-second tick, one clock wide |
| susp_lowpwr | input | 1 | Low-power suspend request |
| susp_debug | input | 1 | Debug-halt suspend request |
| susp_wait | input | 1 | Wait-mode suspend request |
| rst_req | output | 1 | Watchdog reset request pulse |
| tout_pin | output | 1 | Timeout pin, sticky until system reset |

## Verification
The assertions assume that tick_half is at most one clock wide and is synchronous to clk. They also assume that each write is a one-cycle strobe with stable address and data, and that a reset is held for at least one clock edge. The bench drives every input one time unit after a rising edge and drops tick and write strobes after one clock. It leaves at least two idle clocks between ticks. It holds each reset for two or more clocks and waits for the synchronizers to release before it drives any stimulus.

// File: rtl/keysvc_wdog_pkg.sv
`timescale 1ns/1ps
package keysvc_wdog_pkg;
  localparam int unsigned WD_REG_W  = 16;
  localparam int unsigned WD_ADDR_W = 3;
  localparam int unsigned WD_TO_W   = 8;
  localparam int unsigned WD_TO_LSB = 8;
  localparam int unsigned WD_STAT_W = 2;
  localparam int unsigned WD_CNT_W  = WD_TO_W + 1;

  localparam logic [WD_ADDR_W-1:0] OFS_CTRL = 3'h0;
  localparam logic [WD_ADDR_W-1:0] OFS_SVC  = 3'h2;
  localparam logic [WD_ADDR_W-1:0] OFS_STAT = 3'h4;

  localparam int unsigned CB_LP   = 0;
  localparam int unsigned CB_DBG  = 1;
  localparam int unsigned CB_EN   = 2;
  localparam int unsigned CB_PIN  = 3;
  localparam int unsigned CB_WAIT = 7;

  localparam logic [WD_REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [WD_REG_W-1:0] KEY_SECOND = 16'hAAAA;

  localparam logic [WD_STAT_W-1:0] STAT_POR  = 2'b01;
  localparam logic [WD_STAT_W-1:0] STAT_WDOG = 2'b10;

  typedef logic [WD_REG_W-1:0] wd_word_t;

  typedef struct packed {
    logic [WD_TO_W-1:0] tsel;
    logic               sus_wait;
    logic               pin_mode;
    logic               en;
    logic               sus_dbg;
    logic               sus_lp;
  } wd_ctrl_t;
endpackage

// File: rtl/keysvc_wdog_rstsync.sv
`timescale 1ns/1ps
module keysvc_wdog_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/keysvc_wdog_ctrl.sv
`timescale 1ns/1ps
module keysvc_wdog_ctrl
  import keysvc_wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  wd_word_t           wdata,
  output wd_ctrl_t           ctrl_q,
  output logic [WD_TO_W-1:0] tsel_nxt
);
  wd_ctrl_t ctrl_d;
  logic     unused_wbits;

  assign unused_wbits = ^wdata[6:4];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.tsel     = wdata[WD_TO_LSB +: WD_TO_W];
      ctrl_d.sus_lp   = wdata[CB_LP];
      ctrl_d.sus_dbg  = wdata[CB_DBG];
      ctrl_d.pin_mode = wdata[CB_PIN];
      ctrl_d.sus_wait = wdata[CB_WAIT];
      ctrl_d.en       = ctrl_q.en | wdata[CB_EN];
    end
  end

  assign tsel_nxt = ctrl_d.tsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/keysvc_wdog_keyseq.sv
`timescale 1ns/1ps
module keysvc_wdog_keyseq
  import keysvc_wdog_pkg::*;
#(
  parameter wd_word_t FIRST  = KEY_FIRST,
  parameter wd_word_t SECOND = KEY_SECOND
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_svc,
  input  wd_word_t wdata,
  output logic     svc_ok
);
  logic armed_q;
  logic armed_d;

  assign svc_ok  = wr_svc && armed_q && (wdata == SECOND);
  assign armed_d = (wdata == FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_svc) armed_q <= armed_d;
  end
endmodule

// File: rtl/keysvc_wdog_counter.sv
`timescale 1ns/1ps
module keysvc_wdog_counter
  import keysvc_wdog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [WD_TO_W-1:0]  tsel,
  input  logic [WD_TO_W-1:0]  tsel_nxt,
  input  logic                reload,
  input  logic                step,
  output logic                expire,
  output logic [WD_CNT_W-1:0] cnt_q
);
  logic [WD_CNT_W-1:0] cnt_d;
  logic [WD_CNT_W-1:0] reload_val;
  logic [WD_CNT_W-1:0] track_val;
  logic                cnt_ce;

  assign reload_val = {1'b0, tsel} + WD_CNT_W'(1);
  assign track_val  = {1'b0, tsel_nxt} + WD_CNT_W'(1);
  assign cnt_ce     = !en || reload || step;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (!en) begin
      cnt_d = track_val;
    end else if (reload) begin
      cnt_d = reload_val;
    end else if (step) begin
      if (cnt_q == WD_CNT_W'(1)) begin
        expire = 1'b1;
        cnt_d  = reload_val;
      end else begin
        cnt_d = cnt_q - WD_CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= WD_CNT_W'(1);
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/keysvc_wdog.sv
`timescale 1ns/1ps
module keysvc_wdog
  import keysvc_wdog_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [WD_ADDR_W-1:0] reg_addr,
  input  logic [WD_REG_W-1:0]  reg_wdata,
  output logic [WD_REG_W-1:0]  reg_rdata,
  input  logic                 tick_half,
  input  logic                 susp_lowpwr,
  input  logic                 susp_debug,
  input  logic                 susp_wait,
  output logic                 rst_req,
  output logic                 tout_pin
);
  logic                 sys_arst_n;
  logic                 sys_srst_n;
  logic                 por_srst_n;
  logic                 wr_ctrl;
  logic                 wr_svc;
  wd_ctrl_t             ctrl_q;
  logic [WD_TO_W-1:0]   tsel_nxt;
  logic                 svc_ok;
  logic                 frozen;
  logic                 step;
  logic                 expire;
  logic [WD_CNT_W-1:0]  cnt_q;
  logic                 fire_q;
  logic                 pin_q;
  logic                 pin_d;
  logic [WD_STAT_W-1:0] stat_q;
  wd_word_t             ctrl_word;

  assign sys_arst_n = rst_n & por_n;

  keysvc_wdog_rstsync #(.STAGES(SYNC_STAGES)) u_sync_sys (
    .clk(clk), .arst_n(sys_arst_n), .srst_n(sys_srst_n));

  keysvc_wdog_rstsync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk(clk), .arst_n(por_n), .srst_n(por_srst_n));

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_svc  = reg_wr && (reg_addr == OFS_SVC);

  keysvc_wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(sys_srst_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .tsel_nxt(tsel_nxt));

  keysvc_wdog_keyseq u_keys (
    .clk(clk), .rst_n(sys_srst_n), .wr_svc(wr_svc), .wdata(reg_wdata),
    .svc_ok(svc_ok));

  assign frozen = (susp_lowpwr && ctrl_q.sus_lp)
               || (susp_debug  && ctrl_q.sus_dbg)
               || (susp_wait   && ctrl_q.sus_wait);
  assign step   = tick_half && !frozen;

  keysvc_wdog_counter u_cnt (
    .clk(clk), .rst_n(sys_srst_n), .en(ctrl_q.en), .tsel(ctrl_q.tsel),
    .tsel_nxt(tsel_nxt), .reload(svc_ok), .step(step), .expire(expire),
    .cnt_q(cnt_q));

  // reset request and timeout pin: system reset domain
  assign pin_d = pin_q | (fire_q & ctrl_q.pin_mode);

  always_ff @(posedge clk or negedge sys_srst_n) begin
    if (!sys_srst_n) begin
      fire_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      fire_q <= expire;
      pin_q  <= pin_d;
    end
  end

  // reset cause: power-on domain only
  always_ff @(posedge clk or negedge por_srst_n) begin
    if (!por_srst_n)  stat_q <= STAT_POR;
    else if (fire_q)  stat_q <= STAT_WDOG;
  end

  always_comb begin
    ctrl_word                          = '0;
    ctrl_word[WD_TO_LSB +: WD_TO_W]    = ctrl_q.tsel;
    ctrl_word[CB_LP]                   = ctrl_q.sus_lp;
    ctrl_word[CB_DBG]                  = ctrl_q.sus_dbg;
    ctrl_word[CB_EN]                   = ctrl_q.en;
    ctrl_word[CB_PIN]                  = ctrl_q.pin_mode;
    ctrl_word[CB_WAIT]                 = ctrl_q.sus_wait;
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_word;
      OFS_STAT: reg_rdata = {{(WD_REG_W-WD_STAT_W){1'b0}}, stat_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign rst_req  = fire_q;
  assign tout_pin = pin_q;
endmodule

// File: rtl/keysvc_wdog_chk.sv
`timescale 1ns/1ps
module keysvc_wdog_chk
  import keysvc_wdog_pkg::*;
(
  input logic                 clk,
  input logic                 srst_n,
  input logic                 psrst_n,
  input logic                 reg_wr,
  input logic [WD_ADDR_W-1:0] reg_addr,
  input logic                 tick_half,
  input logic                 en,
  input logic                 pin_mode,
  input logic                 svc_ok,
  input logic [WD_CNT_W-1:0]  cnt,
  input logic [WD_TO_W-1:0]   tsel,
  input logic                 rst_req,
  input logic                 tout_pin,
  input logic [WD_STAT_W-1:0] stat
);
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |=> !rst_req);

  p_fire_after_tick_r6: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> $past(tick_half));

  p_no_fire_disabled_r5: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> $past(en));

  p_en_sticky_r5: assert property (@(posedge clk) disable iff (!srst_n)
    en |=> en);

  p_reload_value_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (svc_ok && en) |=> (cnt == (WD_CNT_W'($past(tsel)) + WD_CNT_W'(1))));

  p_pin_needs_mode_r7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(tout_pin) |-> $past(pin_mode));

  p_stat_readonly_r9: assert property (@(posedge clk) disable iff (!psrst_n)
    (reg_wr && (reg_addr == OFS_STAT) && !rst_req) |=> $stable(stat));
endmodule

bind keysvc_wdog keysvc_wdog_chk u_chk (
  .clk(clk), .srst_n(sys_srst_n), .psrst_n(por_srst_n), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .tick_half(tick_half), .en(ctrl_q.en),
  .pin_mode(ctrl_q.pin_mode), .svc_ok(svc_ok), .cnt(cnt_q),
  .tsel(ctrl_q.tsel), .rst_req(rst_req), .tout_pin(tout_pin), .stat(stat_q));

// File: tb/keysvc_wdog_tb.sv
`timescale 1ns/1ps
module keysvc_wdog_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'h0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        tick_half = 1'b0;
  logic        susp_lowpwr = 1'b0;
  logic        susp_debug = 1'b0;
  logic        susp_wait = 1'b0;
  logic        rst_req;
  logic        tout_pin;

  int checks = 0;
  int failures = 0;
  int fires = 0;
  logic [15:0] rd_val;

  always #2.5 clk = ~clk;

  keysvc_wdog u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_half(tick_half), .susp_lowpwr(susp_lowpwr), .susp_debug(susp_debug),
    .susp_wait(susp_wait), .rst_req(rst_req), .tout_pin(tout_pin));

  // behavioural reference model
  int m_q1, m_q2, m_to, m_cnt, m_stat;
  bit m_en, m_lp, m_dbg, m_pin_mode, m_wait, m_armed, m_fire, m_pin;

  task automatic model_sys_reset();
    m_q1 = 0; m_q2 = 0; m_to = 0; m_cnt = 1;
    m_en = 0; m_lp = 0; m_dbg = 0; m_pin_mode = 0; m_wait = 0;
    m_armed = 0; m_fire = 0; m_pin = 0;
  endtask

  always @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) begin
      model_sys_reset();
      if (!por_n) m_stat = 1;
    end else if (m_q2 == 0) begin
      m_q2 = m_q1;
      m_q1 = 1;
    end else if (clk) begin
      bit ok, frz, nf;
      int nto;
      if (m_fire) m_stat = 2;
      if (m_fire && m_pin_mode) m_pin = 1;
      ok  = reg_wr && reg_addr == 3'h2 && reg_wdata == 16'hAAAA && m_armed;
      frz = (susp_lowpwr && m_lp) || (susp_debug && m_dbg) || (susp_wait && m_wait);
      nto = (reg_wr && reg_addr == 3'h0) ? int'(reg_wdata[15:8]) : m_to;
      nf  = 0;
      if (!m_en) m_cnt = nto + 1;
      else if (ok) m_cnt = m_to + 1;
      else if (tick_half && !frz) begin
        if (m_cnt == 1) begin nf = 1; m_cnt = m_to + 1; end
        else m_cnt = m_cnt - 1;
      end
      m_fire = nf;
      if (reg_wr && reg_addr == 3'h2) m_armed = (reg_wdata == 16'h5555);
      if (reg_wr && reg_addr == 3'h0) begin
        m_to = nto; m_lp = reg_wdata[0]; m_dbg = reg_wdata[1];
        m_pin_mode = reg_wdata[3]; m_wait = reg_wdata[7];
        m_en = m_en | reg_wdata[2];
      end
    end
  end

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'h0: return {m_to[7:0], m_wait, 3'b000, m_pin_mode, m_en, m_dbg, m_lp};
      3'h4: return 16'(m_stat);
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_req) fires++;
    chk(rst_req === m_fire, "R6 rst_req vs model", int'(rst_req), int'(m_fire));
    chk(tout_pin === m_pin, "R7 tout_pin vs model", int'(tout_pin), int'(m_pin));
    chk(reg_rdata === model_read(reg_addr), "R1 rdata vs model",
        int'(reg_rdata), int'(model_read(reg_addr)));
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick_half = 1'b1;
      @(posedge clk); #1; tick_half = 1'b0;
      repeat (2) @(posedge clk);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timer expired in bench");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; por_n = 1'b1; rst_n = 1'b1;
    settle();
    rd(3'h4, rd_val); chk(rd_val == 16'h0001, "R9 power-on status", rd_val, 16'h0001);
    rd(3'h0, rd_val); chk(rd_val == 16'h0000, "R1 control reset value", rd_val, 0);

    // N=0 enable: first tick fires
    wr(3'h0, 16'h0004);
    rd(3'h0, rd_val); chk(rd_val == 16'h0004, "R1 control readback", rd_val, 16'h0004);
    ticks(1); chk(fires == 1, "R4 N=0 fires on first tick", fires, 1);
    rd(3'h4, rd_val); chk(rd_val == 16'h0002, "R9 status after expiry", rd_val, 2);
    wr(3'h4, 16'hFFFF);
    rd(3'h4, rd_val); chk(rd_val == 16'h0002, "R9 status write ignored", rd_val, 2);
    chk(tout_pin == 1'b0, "R7 pin low without mode", int'(tout_pin), 0);

    // enable stays set
    wr(3'h0, 16'h0000);
    rd(3'h0, rd_val); chk(rd_val == 16'h0004, "R5 enable not clearable", rd_val, 16'h0004);

    // field rewrite does not touch running count
    wr(3'h0, 16'h0304);
    ticks(1); chk(fires == 2, "R10 old count kept after field rewrite", fires, 2);
    ticks(3); chk(fires == 2, "R4 N=3 no fire before 4th tick", fires, 2);
    ticks(1); chk(fires == 3, "R4 N=3 fires on 4th tick", fires, 3);

    // valid service
    ticks(2);
    wr(3'h2, 16'h5555); wr(3'h2, 16'hAAAA);
    ticks(3); chk(fires == 3, "R2 service reloaded count", fires, 3);
    ticks(1); chk(fires == 4, "R2 fire after full reload", fires, 4);

    // broken sequences
    ticks(2);
    wr(3'h2, 16'h5555); wr(3'h2, 16'h1234); wr(3'h2, 16'hAAAA);
    ticks(1); chk(fires == 4, "R3 count continues", fires, 4);
    ticks(1); chk(fires == 5, "R3 interrupted key pair ignored", fires, 5);
    ticks(2);
    wr(3'h2, 16'hAAAA);
    ticks(2); chk(fires == 6, "R3 lone second key ignored", fires, 6);
    ticks(2);
    wr(3'h2, 16'h5555); wr(3'h2, 16'h5555); wr(3'h2, 16'hAAAA);
    ticks(3); chk(fires == 6, "R2 repeated first key accepted", fires, 6);
    ticks(1); chk(fires == 7, "R2 fire after repeated-key reload", fires, 7);

    // suspend inputs
    wr(3'h0, 16'h0305);
    susp_lowpwr = 1'b1; ticks(6); susp_lowpwr = 1'b0;
    chk(fires == 7, "R8 low-power suspend freezes", fires, 7);
    susp_debug = 1'b1; ticks(4); susp_debug = 1'b0;
    chk(fires == 8, "R8 debug suspend ignored without bit 1", fires, 8);
    wr(3'h0, 16'h0385);
    susp_wait = 1'b1; ticks(5); susp_wait = 1'b0;
    chk(fires == 8, "R8 wait suspend freezes", fires, 8);
    ticks(4); chk(fires == 9, "R8 count resumes after suspend", fires, 9);

    // timeout pin
    wr(3'h0, 16'h000D);
    ticks(3); chk(tout_pin == 1'b0, "R7 pin low before expiry", int'(tout_pin), 0);
    ticks(1); chk(fires == 10, "R6 expiry with pin mode", fires, 10);
    chk(tout_pin == 1'b1, "R7 pin high after expiry", int'(tout_pin), 1);
    ticks(1); chk(tout_pin == 1'b1 && fires == 11, "R7 pin stays high", int'(tout_pin), 1);

    // system reset only
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk); #1; rst_n = 1'b1;
    settle();
    rd(3'h4, rd_val); chk(rd_val == 16'h0002, "R9 status survives system reset", rd_val, 2);
    rd(3'h0, rd_val); chk(rd_val == 16'h0000, "R5 system reset clears enable", rd_val, 0);
    chk(tout_pin == 1'b0, "R7 pin cleared by system reset", int'(tout_pin), 0);
    ticks(3); chk(fires == 11, "R5 disabled counter ignores ticks", fires, 11);
    wr(3'h0, 16'h0070);
    rd(3'h0, rd_val); chk(rd_val == 16'h0000, "R1 bits 6..4 read zero", rd_val, 0);
    rd(3'h2, rd_val); chk(rd_val == 16'h0000, "R1 service reads zero", rd_val, 0);

    // enabling write loads its own field
    wr(3'h0, 16'h0104);
    ticks(1); chk(fires == 11, "R11 first tick after enable", fires, 11);
    ticks(1); chk(fires == 12, "R11 enable loads N+1 from same write", fires, 12);

    // power-on reset
    @(posedge clk); #1; por_n = 1'b0;
    repeat (2) @(posedge clk); #1; por_n = 1'b1;
    settle();
    rd(3'h4, rd_val); chk(rd_val == 16'h0001, "R9 power-on status again", rd_val, 1);

    summary();
    $finish;
  end
endmodule